// File: doc/BRIEF.md
# First-Edge Race Arbiter

This block watches three asynchronous single-bit inputs: a reference line and two contender lines. Each time the reference line goes from high to low, a new race starts. The block reports which contender produces the first low-to-high transition during that race. The one-bit result is 0 when the left contender wins and 1 when the right contender wins. Once a race is decided, the result stays frozen. It is not cleared by a later race being armed. It only changes when a later race is actually decided. This means a consumer can read it at any time while the reference line is high.

All three inputs pass through two-flop synchronisers in the system clock domain. Edges are found by comparing each synchronised sample with the one taken on the previous clock. The clock period must be shorter than the narrowest contender pulse. With 50 ns pulses, the 8 ns clock used here leaves ample margin. A freshness flag tells a fresh decision apart from a value carried over from an earlier race.

Top module: `race_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `winner` becomes 0 and `winnerValid` becomes 0. No race is armed after reset.
- R2: A high-to-low transition of `refIn` arms a race and clears `winnerValid`. A low-to-high transition of `refIn` does not arm a race.
- R3: In an armed race, a rising edge on `leftIn` alone sets `winner` to 0, and a rising edge on `rightIn` alone sets `winner` to 1. Either one sets `winnerValid` to 1 and ends the race.
- R4: After a race is decided, further rising edges on `leftIn` or `rightIn` have no effect on `winner` or `winnerValid` until `refIn` falls again.
- R5: A contender that is already high when the race is armed does not win by level. It must go low and then rise again while the race is armed.
- R6: While `refIn` is high, the contenders are not observed. A rise of `refIn` closes an undecided race, and the previous `winner` is kept.
- R7: Arming a new race leaves the value of `winner` unchanged.
- R8: If both contenders show a rising edge in the same synchronised sample of an armed race, the left contender wins (`winner` = 0).
- R9: A contender edge seen in the same synchronised sample as the arming fall of `refIn` is not counted for that race.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | 1 | Asynchronous reference line; its falling edge starts a race |
| leftIn | input | 1 | Asynchronous left contender; a win gives result 0 |
| rightIn | input | 1 | Asynchronous right contender; a win gives result 1 |
| winner | output | 1 | Decided winner: 0 left, 1 right |
| winnerValid | output | 1 | High once the current race has been decided |

## Verification
The bench sweeps every sequence of three successive input vectors over the three lines. Each vector is held long enough to be synchronised on its own. This covers arming with contenders already high, single and simultaneous contender rises, edges that coincide with either transition of the reference line, and edges after a decision. A reference model computes the expected result and freshness flag after every vector, so a tie resolved the wrong way, a level mistaken for an edge, or a race left open past the reference rise each gives a mismatch. Directed sequences add reset, a tie, and a right-contender win followed by a late left edge.

// File: rtl/race_pkg.sv
package race_pkg;

  // Edge events found in the synchronised samples
  typedef struct packed {
    logic refFall;
    logic refRise;
    logic leftRise;
    logic rightRise;
  } raceEdges_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic arm;
    logic takeLeft;
    logic takeRight;
  } raceStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DONE  = 2'd2
  } raceState_t;

  localparam int LINE_COUNT = 3;
  localparam int LINE_REF   = 0;
  localparam int LINE_LEFT  = 1;
  localparam int LINE_RIGHT = 2;

endpackage

// File: rtl/race_sync.sv
module race_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/race_datapath.sv
module race_datapath
  import race_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         refIn,
  input  logic         leftIn,
  input  logic         rightIn,
  input  raceStrobes_t strobes,
  output raceEdges_t   edges,
  output logic         winner,
  output logic         winnerValid
);

  logic [LINE_COUNT-1:0] rawLines;
  logic [LINE_COUNT-1:0] syncLines;
  logic [LINE_COUNT-1:0] prevLines;
  logic [LINE_COUNT-1:0] riseLines;
  logic [LINE_COUNT-1:0] fallLines;
  logic winnerQ;
  logic validQ;

  assign rawLines[LINE_REF]   = refIn;
  assign rawLines[LINE_LEFT]  = leftIn;
  assign rawLines[LINE_RIGHT] = rightIn;

  race_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_COUNT)) i_sync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(rawLines),
    .syncOut(syncLines)
  );

  always_ff @(posedge clk) begin
    if (rst) prevLines <= '0;
    else     prevLines <= syncLines;
  end

  generate
    for (genvar i = 0; i < LINE_COUNT; i++) begin : g_edge
      assign riseLines[i] = syncLines[i] & ~prevLines[i];
      assign fallLines[i] = ~syncLines[i] & prevLines[i];
    end
  endgenerate

  assign edges.refFall   = fallLines[LINE_REF];
  assign edges.refRise   = riseLines[LINE_REF];
  assign edges.leftRise  = riseLines[LINE_LEFT];
  assign edges.rightRise = riseLines[LINE_RIGHT];

  // Result register: only changes on a capture strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      winnerQ <= 1'b0;
    end else if (strobes.takeLeft) begin
      winnerQ <= 1'b0;
    end else if (strobes.takeRight) begin
      winnerQ <= 1'b1;
    end
  end

  // Freshness flag: cleared on arming, set on capture
  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
    end else if (strobes.arm) begin
      validQ <= 1'b0;
    end else if (strobes.takeLeft || strobes.takeRight) begin
      validQ <= 1'b1;
    end
  end

  assign winner      = winnerQ;
  assign winnerValid = validQ;

endmodule

// File: rtl/race_control.sv
module race_control
  import race_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  raceEdges_t   edges,
  output raceStrobes_t strobes,
  output logic         armed
);

  raceState_t stateQ;
  raceState_t stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    if (edges.refFall) begin
      // A new race starts; contender edges in this sample are not counted
      strobes.arm = 1'b1;
      stateD      = ST_ARMED;
    end else if (stateQ == ST_ARMED) begin
      if (edges.refRise) begin
        stateD = ST_IDLE;
      end else if (edges.leftRise) begin
        // left has priority on a tie
        strobes.takeLeft = 1'b1;
        stateD           = ST_DONE;
      end else if (edges.rightRise) begin
        strobes.takeRight = 1'b1;
        stateD            = ST_DONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign armed = (stateQ == ST_ARMED);

endmodule

// File: rtl/race_arbiter.sv
module race_arbiter
  import race_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refIn,
  input  logic leftIn,
  input  logic rightIn,
  output logic winner,
  output logic winnerValid
);

  raceEdges_t   edges;
  raceStrobes_t strobes;
  logic         armed;

  race_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .refIn      (refIn),
    .leftIn     (leftIn),
    .rightIn    (rightIn),
    .strobes    (strobes),
    .edges      (edges),
    .winner     (winner),
    .winnerValid(winnerValid)
  );

  race_control i_control (
    .clk    (clk),
    .rst    (rst),
    .edges  (edges),
    .strobes(strobes),
    .armed  (armed)
  );

endmodule

// File: rtl/race_arbiter_chk.sv
module race_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic winner,
  input logic winnerValid,
  input logic armed,
  input logic refFall,
  input logic refRise,
  input logic refHigh,
  input logic leftRise,
  input logic rightRise
);

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!winner && !winnerValid && !armed));

  // R2
  arm_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    refFall |=> (armed && !winnerValid));

  // R7
  arm_keeps_winner_chk: assert property (@(posedge clk) disable iff (rst)
    refFall |=> $stable(winner));

  // R4
  decided_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (winnerValid && !refFall) |=> ($stable(winner) && winnerValid));

  // R6
  ref_high_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (refHigh && !refRise) |=> $stable(winner));

  // R6
  ref_rise_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && refRise) |=> (!armed && $stable(winner) && !winnerValid));

  // R3
  right_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !refRise && rightRise && !leftRise) |=> (winner && winnerValid));

  // R8
  left_wins_tie_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !refRise && leftRise) |=> (!winner && winnerValid));

endmodule

bind race_arbiter race_arbiter_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .winner     (winner),
  .winnerValid(winnerValid),
  .armed      (armed),
  .refFall    (edges.refFall),
  .refRise    (edges.refRise),
  .refHigh    (i_datapath.syncLines[0]),
  .leftRise   (edges.leftRise),
  .rightRise  (edges.rightRise)
);

// File: tb/test_race_arbiter.sv
module test_race_arbiter;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refIn = 1'b0;
  logic leftIn = 1'b0;
  logic rightIn = 1'b0;
  logic winner;
  logic winnerValid;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic mArmed = 1'b0;
  logic mWin = 1'b0;
  logic mValid = 1'b0;
  logic pA = 1'b0;
  logic pB = 1'b0;
  logic pC = 1'b0;

  always #4 clk = ~clk;

  race_arbiter i_race_arbiter (
    .clk        (clk),
    .rst        (rst),
    .refIn      (refIn),
    .leftIn     (leftIn),
    .rightIn    (rightIn),
    .winner     (winner),
    .winnerValid(winnerValid)
  );

  task automatic check(input string tag, input logic expW, input logic expV);
    checks++;
    if (winner !== expW || winnerValid !== expV) begin
      errors++;
      $display("FAIL %s: winner=%b valid=%b expected winner=%b valid=%b",
               tag, winner, winnerValid, expW, expV);
    end
  endtask

  // Drive one vector {a,b,c}, let it settle, update the model, compare.
  task automatic step(input logic [2:0] v);
    logic a, b, c;
    logic fall, rise, bR, cR;
    string tag;
    a = v[2]; b = v[1]; c = v[0];
    @(negedge clk);
    refIn = a; leftIn = b; rightIn = c;
    repeat (5) @(negedge clk);
    fall = pA && !a;
    rise = !pA && a;
    bR = !pB && b;
    cR = !pC && c;
    tag = "R4";
    if (fall) begin
      mArmed = 1'b1; mValid = 1'b0;
      tag = (bR || cR) ? "R9" : "R2,R7";
    end else if (mArmed) begin
      if (rise) begin
        mArmed = 1'b0; tag = "R6";
      end else if (bR) begin
        mWin = 1'b0; mValid = 1'b1; mArmed = 1'b0;
        tag = cR ? "R8" : "R3";
      end else if (cR) begin
        mWin = 1'b1; mValid = 1'b1; mArmed = 1'b0; tag = "R3";
      end else begin
        tag = "R5";
      end
    end else if (a) begin
      tag = rise ? "R2" : "R6";
    end
    pA = a; pB = b; pC = c;
    check(tag, mWin, mValid);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    // directed: right wins, then a late left edge is ignored
    step(3'b100); step(3'b000); step(3'b001); step(3'b000);
    step(3'b010); step(3'b110);
    // directed: tie after arming
    step(3'b000); step(3'b011); step(3'b000);
    // directed: contender high across arming
    step(3'b110); step(3'b010); step(3'b000); step(3'b010);

    // exhaustive sweep over three successive vectors
    for (int s0 = 0; s0 < 8; s0++)
      for (int s1 = 0; s1 < 8; s1++)
        for (int s2 = 0; s2 < 8; s2++) begin
          step(3'(s0)); step(3'(s1)); step(3'(s2));
        end

    // reset in the middle of a decided state
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule